// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host write path and a program/erase engine inside a flash memory controller. Each accepted write carries a command byte in the low eight data bits, or a payload when a two-cycle command is waiting for its second cycle. The block decodes these writes and keeps track of the state of the program/erase controller, including setup, running, suspending and suspended phases. From that state it chooses what a read returns: array contents, the status byte, the identification codes or the query table. It also keeps a status byte whose error flags stay set until software clears them.

The engine that actually programs and erases the cells lives outside the block. This block gives it one-cycle request pulses: start (with operation, address and data), suspend, resume and abort. The engine answers with a level that is high while it works and a failure flag that is sampled when that level drops. Two plain inputs screen every operation before it starts: one says the target block is protected, the other says the program voltage is adequate. Array and query data come from outside the block. Only the status byte and the identification codes are produced here.

Writes use a valid/ready handshake, and a write is accepted on a clock edge where both are high. Ready goes low only while the block waits for the engine. That covers two cases: after a start or resume request until the engine shows busy, and after a suspend request until the engine goes idle. A host holding valid simply waits; the write is neither lost nor duplicated.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rd_mode is 00 (array), status is 80h with bit 0 copying tune_locked, wr_ready is 1 and bcr holds BCR_RST.
- R2: A write in the idle state selects the read mode. FFh gives 00 (array), 70h gives 01 (status), 90h gives 10 (identification) and 98h gives 11 (query). In mode 01, rd_data carries the status byte in bits 7..0. In mode 10, rd_data is MFR_CODE when rd_idx is 0 and DEV_CODE when rd_idx is 1.
- R3: A write of 20h followed by D0h starts an erase. In the cycle after D0h is accepted, eng_start is high for exactly one cycle, with eng_op 0 and eng_addr equal to the D0h write address. When the engine drops busy, status bit 7 returns to 1; if eng_fail is high at that moment, bit 5 is set.
- R4: A write of 40h followed by a payload write starts a program. eng_start pulses with eng_op 1 and carries the payload's address and data. If the engine reports a failure, bit 4 is set.
- R5: B0h written during a running erase or program pulses eng_suspend. Once the engine is idle, status shows bit 7 = 1 together with bit 6 (erase held) or bit 2 (program held), never both bits. D0h then pulses eng_resume.
- R6: While an erase is held, reads may select array mode, and a 40h plus payload sequence runs a program with bit 6 kept at 1. When that program finishes, the block returns to the held erase.
- R7: While status bit 7 is 0, rd_mode reads 01. A read-select write accepted in that time takes effect once the operation ends.
- R8: A second cycle other than D0h after 20h, or other than 03h after 60h, sets status bits 5 and 4.
- R9: If prot_hit is high on the confirming or payload write, status bit 1 is set and no eng_start is issued.
- R10: If vpp_ok is low on the confirming or payload write, bit 3 is set and nothing starts. If vpp_ok falls during a run, eng_abort pulses in the next cycle, bit 3 is set and bit 7 returns to 1.
- R11: While any of status bits 5, 4, 3 or 1 is set, 20h and 40h enter no setup, so the following write starts nothing. A write of 50h clears those four bits.
- R12: A write of 60h followed by 03h loads bcr from wr_addr[15:0]. Any other second cycle leaves bcr unchanged.
- R13: wr_ready is 0 in the cycle after a start or resume request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits 7..0 are the command byte |
| rd_idx | input | 1 | Selects manufacturer (0) or device (1) code in identification mode |
| rd_data | output | DATA_W | Status or identification word for the current read mode |
| rd_mode | output | 2 | Effective read mode: 00 array, 01 status, 10 identification, 11 query |
| status | output | 8 | Status byte |
| bcr | output | BCR_W | Burst configuration value |
| prot_hit | input | 1 | The target of the current write lies in a protected block |
| vpp_ok | input | 1 | Program voltage is above the lockout level |
| tune_locked | input | 1 | Tuning-protection state, shown in status bit 0 |
| eng_busy | input | 1 | Engine is working |
| eng_fail | input | 1 | Engine reports failure when busy drops |
| eng_start | output | 1 | One-cycle start request |
| eng_op | output | 1 | Operation for start: 0 erase, 1 program |
| eng_addr | output | ADDR_W | Target address for start |
| eng_data | output | DATA_W | Program data for start |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| eng_abort | output | 1 | One-cycle abort on program-voltage loss |

## Verification
The bench keeps the 19-bit address, 32-bit data and 16-bit configuration widths at their defaults. It overrides DEV_CODE to 8836h, so the identification check shows that the parameter reaches the read path rather than a fixed constant. A behavioural engine in the bench has a latency that can be set per test. A long latency leaves room to suspend, run a nested program inside a held erase and then resume. A short latency keeps the completion and failure paths quick.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIGN   = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ERS_SET,
    S_PRG_SET,
    S_CFG_SET,
    S_ERS_RUN,
    S_PRG_RUN,
    S_ERS_HOLDING,
    S_PRG_HOLDING,
    S_ERS_HELD,
    S_PRG_HELD,
    S_NEST_SET,
    S_NEST_RUN
  } st_e;

  typedef enum logic {
    OP_ERASE = 1'b0,
    OP_PROG  = 1'b1
  } op_e;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_SIGN    = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_PROG    = 8'h40;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_CFG     = 8'h60;
  localparam logic [7:0] C_CFG_OK  = 8'h03;

  function automatic logic is_run(st_e s);
    return s inside {S_ERS_RUN, S_PRG_RUN, S_NEST_RUN};
  endfunction

  function automatic logic is_holding(st_e s);
    return s inside {S_ERS_HOLDING, S_PRG_HOLDING};
  endfunction

  function automatic logic is_read_cmd(logic [7:0] c);
    return c inside {C_ARRAY, C_STATUS, C_SIGN, C_QUERY};
  endfunction

  function automatic rmode_e mode_of(logic [7:0] c);
    case (c)
      C_STATUS: return RM_STATUS;
      C_SIGN:   return RM_SIGN;
      C_QUERY:  return RM_QUERY;
      default:  return RM_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BCR_W  = 16,
  parameter logic [BCR_W-1:0] BCR_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [7:0]        cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prot_hit,
  input  logic              vpp_ok,
  input  logic              eng_busy,
  input  logic              eng_fail,
  output st_e               st,
  output rmode_e            sel_mode,
  output logic              seen_busy,
  output logic [3:0]        err,
  output logic              eng_start,
  output op_e               eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_data,
  output logic              eng_suspend,
  output logic              eng_resume,
  output logic              eng_abort,
  output logic [BCR_W-1:0]  bcr
);

  // err bit map: 3 erase, 2 program, 1 voltage, 0 protected block
  localparam int E_ERS = 3;
  localparam int E_PRG = 2;
  localparam int E_VPP = 1;
  localparam int E_PRT = 0;

  logic err_any;
  assign err_any = |err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      sel_mode    <= RM_ARRAY;
      seen_busy   <= 1'b0;
      err         <= '0;
      eng_start   <= 1'b0;
      eng_op      <= OP_ERASE;
      eng_addr    <= '0;
      eng_data    <= '0;
      eng_suspend <= 1'b0;
      eng_resume  <= 1'b0;
      eng_abort   <= 1'b0;
      bcr         <= BCR_RST;
    end else begin
      eng_start   <= 1'b0;
      eng_suspend <= 1'b0;
      eng_resume  <= 1'b0;
      eng_abort   <= 1'b0;
      if (is_run(st) && eng_busy) seen_busy <= 1'b1;

      case (st)
        S_IDLE: if (wr_fire) begin
          if (is_read_cmd(cmd)) sel_mode <= mode_of(cmd);
          else if (cmd == C_CLEAR) err <= '0;
          else if (cmd == C_ERASE) begin
            sel_mode <= RM_STATUS;
            if (!err_any) st <= S_ERS_SET;
          end else if (cmd == C_PROG) begin
            sel_mode <= RM_STATUS;
            if (!err_any) st <= S_PRG_SET;
          end else if (cmd == C_CFG) st <= S_CFG_SET;
        end

        S_ERS_SET: if (wr_fire) begin
          sel_mode <= RM_STATUS;
          st       <= S_IDLE;
          if (cmd != C_CONFIRM) begin
            err[E_ERS] <= 1'b1;
            err[E_PRG] <= 1'b1;
          end else if (prot_hit) err[E_PRT] <= 1'b1;
          else if (!vpp_ok) err[E_VPP] <= 1'b1;
          else begin
            eng_start <= 1'b1;
            eng_op    <= OP_ERASE;
            eng_addr  <= wr_addr;
            eng_data  <= '0;
            seen_busy <= 1'b0;
            st        <= S_ERS_RUN;
          end
        end

        S_PRG_SET, S_NEST_SET: if (wr_fire) begin
          sel_mode <= RM_STATUS;
          st       <= (st == S_NEST_SET) ? S_ERS_HELD : S_IDLE;
          if (prot_hit) err[E_PRT] <= 1'b1;
          else if (!vpp_ok) err[E_VPP] <= 1'b1;
          else begin
            eng_start <= 1'b1;
            eng_op    <= OP_PROG;
            eng_addr  <= wr_addr;
            eng_data  <= wr_data;
            seen_busy <= 1'b0;
            st        <= (st == S_NEST_SET) ? S_NEST_RUN : S_PRG_RUN;
          end
        end

        S_CFG_SET: if (wr_fire) begin
          st <= S_IDLE;
          if (cmd == C_CFG_OK) bcr <= wr_addr[BCR_W-1:0];
          else begin
            err[E_ERS] <= 1'b1;
            err[E_PRG] <= 1'b1;
            sel_mode   <= RM_STATUS;
          end
        end

        S_ERS_RUN, S_PRG_RUN, S_NEST_RUN: begin
          if (!vpp_ok) begin
            eng_abort  <= 1'b1;
            err[E_VPP] <= 1'b1;
            seen_busy  <= 1'b0;
            st         <= S_IDLE;
          end else if (seen_busy && !eng_busy) begin
            seen_busy <= 1'b0;
            if (eng_fail) begin
              if (st == S_ERS_RUN) err[E_ERS] <= 1'b1;
              else err[E_PRG] <= 1'b1;
            end
            st <= (st == S_NEST_RUN) ? S_ERS_HELD : S_IDLE;
          end else if (wr_fire) begin
            if (cmd == C_SUSP && st != S_NEST_RUN) begin
              eng_suspend <= 1'b1;
              st <= (st == S_ERS_RUN) ? S_ERS_HOLDING : S_PRG_HOLDING;
            end else if (is_read_cmd(cmd)) sel_mode <= mode_of(cmd);
          end
        end

        S_ERS_HOLDING: if (!eng_busy) st <= S_ERS_HELD;
        S_PRG_HOLDING: if (!eng_busy) st <= S_PRG_HELD;

        S_ERS_HELD, S_PRG_HELD: if (wr_fire) begin
          if (is_read_cmd(cmd)) sel_mode <= mode_of(cmd);
          else if (cmd == C_CLEAR) err <= '0;
          else if (cmd == C_CONFIRM) begin
            sel_mode <= RM_STATUS;
            if (!vpp_ok) err[E_VPP] <= 1'b1;
            else begin
              eng_resume <= 1'b1;
              seen_busy  <= 1'b0;
              st <= (st == S_ERS_HELD) ? S_ERS_RUN : S_PRG_RUN;
            end
          end else if (cmd == C_PROG && st == S_ERS_HELD) begin
            sel_mode <= RM_STATUS;
            if (!err_any) st <= S_NEST_SET;
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fci_status_pack.sv
module fci_status_pack
  import fci_pkg::*;
(
  input  st_e        st,
  input  logic [3:0] err,
  input  logic       tune_locked,
  output logic       ready,
  output logic [7:0] status
);

  logic ers_held;
  logic prg_held;

  always_comb begin
    ready    = !(is_run(st) || is_holding(st));
    ers_held = st inside {S_ERS_HELD, S_NEST_SET, S_NEST_RUN};
    prg_held = (st == S_PRG_HELD);
    status   = {ready, ers_held, err[3], err[2], err[1], prg_held, err[0], tune_locked};
  end

endmodule

// File: rtl/fci_read_mux.sv
module fci_read_mux
  import fci_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [15:0] DEV_CODE = 16'h8835
) (
  input  rmode_e            sel_mode,
  input  logic              ready,
  input  logic [7:0]        status,
  input  logic              rd_idx,
  output rmode_e            rd_mode,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD8  = DATA_W - 8;
  localparam int PAD16 = DATA_W - 16;

  always_comb begin
    rd_mode = ready ? sel_mode : RM_STATUS;
    case (rd_mode)
      RM_STATUS: rd_data = {{PAD8{1'b0}}, status};
      RM_SIGN:   rd_data = rd_idx ? {{PAD16{1'b0}}, DEV_CODE}
                                  : {{PAD8{1'b0}}, MFR_CODE};
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BCR_W  = 16,
  parameter logic [BCR_W-1:0] BCR_RST = '0,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [15:0] DEV_CODE = 16'h8835
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_mode,
  output logic [7:0]        status,
  output logic [BCR_W-1:0]  bcr,
  input  logic              prot_hit,
  input  logic              vpp_ok,
  input  logic              tune_locked,
  input  logic              eng_busy,
  input  logic              eng_fail,
  output logic              eng_start,
  output logic              eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_data,
  output logic              eng_suspend,
  output logic              eng_resume,
  output logic              eng_abort
);

  st_e        st_w;
  rmode_e     sel_mode_w;
  rmode_e     rd_mode_w;
  op_e        eng_op_w;
  logic       seen_w;
  logic [3:0] err_w;
  logic       ready_w;
  logic       wr_fire;

  assign wr_ready = !((is_run(st_w) && !seen_w) || is_holding(st_w));
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_mode  = rd_mode_w;
  assign eng_op   = eng_op_w;

  fci_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BCR_W  (BCR_W),
    .BCR_RST(BCR_RST)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .cmd        (wr_data[7:0]),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prot_hit   (prot_hit),
    .vpp_ok     (vpp_ok),
    .eng_busy   (eng_busy),
    .eng_fail   (eng_fail),
    .st         (st_w),
    .sel_mode   (sel_mode_w),
    .seen_busy  (seen_w),
    .err        (err_w),
    .eng_start  (eng_start),
    .eng_op     (eng_op_w),
    .eng_addr   (eng_addr),
    .eng_data   (eng_data),
    .eng_suspend(eng_suspend),
    .eng_resume (eng_resume),
    .eng_abort  (eng_abort),
    .bcr        (bcr)
  );

  fci_status_pack u_stat (
    .st         (st_w),
    .err        (err_w),
    .tune_locked(tune_locked),
    .ready      (ready_w),
    .status     (status)
  );

  fci_read_mux #(
    .DATA_W  (DATA_W),
    .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE)
  ) u_rd (
    .sel_mode(sel_mode_w),
    .ready   (ready_w),
    .status  (status),
    .rd_idx  (rd_idx),
    .rd_mode (rd_mode_w),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/fci_checker.sv
module fci_checker
  import fci_pkg::*;
#(
  parameter int BCR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [7:0]       cmd,
  input logic             vpp_ok,
  input logic             eng_start,
  input logic             eng_abort,
  input logic [7:0]       status,
  input logic [1:0]       rd_mode,
  input logic [BCR_W-1:0] bcr,
  input st_e              st
);

  // R7: a busy controller always presents the status byte
  assert_busy_shows_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> rd_mode == 2'b01);

  // R11: no start while a sticky error was present on the accepting cycle
  assert_start_needs_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(status[5:3] == 3'b000 && status[1] == 1'b0));

  // R10: voltage loss during a run aborts and flags
  assert_vpp_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_run(st) && !vpp_ok) |=> (eng_abort && status[3] && status[7]));

  // R5: erase-held and program-held never together
  assert_held_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[2]));

  // R12: configuration changes only after an accepted 03h
  assert_cfg_load_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bcr) |-> $past(wr_valid && wr_ready && cmd == 8'h03));

  // R3: start request lasts a single cycle
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

endmodule

bind flash_cmd_ctrl fci_checker #(.BCR_W(BCR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .cmd      (wr_data[7:0]),
  .vpp_ok   (vpp_ok),
  .eng_start(eng_start),
  .eng_abort(eng_abort),
  .status   (status),
  .rd_mode  (rd_mode),
  .bcr      (bcr),
  .st       (st_w)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

  localparam int ADDR_W = 19;
  localparam int DATA_W = 32;
  localparam int BCR_W  = 16;
  localparam logic [15:0] DEV = 16'h8836;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_idx = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic [1:0] rd_mode;
  logic [7:0] status;
  logic [BCR_W-1:0] bcr;
  logic prot_hit = 1'b0;
  logic vpp_ok = 1'b1;
  logic tune_locked = 1'b0;
  logic ebusy;
  logic fail_next = 1'b0;
  logic eng_start, eng_op, eng_suspend, eng_resume, eng_abort;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_data;

  int compared = 0;
  int mismatched = 0;
  int starts = 0;
  int lat = 6;
  int rem = 0;
  int saved = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.DEV_CODE(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_mode(rd_mode), .status(status), .bcr(bcr), .prot_hit(prot_hit),
    .vpp_ok(vpp_ok), .tune_locked(tune_locked), .eng_busy(ebusy),
    .eng_fail(fail_next), .eng_start(eng_start), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_data(eng_data), .eng_suspend(eng_suspend),
    .eng_resume(eng_resume), .eng_abort(eng_abort)
  );

  // behavioural program/erase engine
  always @(posedge clk) begin
    if (!rst_n) begin
      ebusy <= 1'b0; rem <= 0; saved <= 0;
    end else if (eng_abort) ebusy <= 1'b0;
    else if (eng_start) begin ebusy <= 1'b1; rem <= lat; end
    else if (eng_suspend) begin ebusy <= 1'b0; saved <= rem; end
    else if (eng_resume) begin ebusy <= 1'b1; rem <= saved; end
    else if (ebusy) begin
      if (rem == 0) ebusy <= 1'b0;
      else rem <= rem - 1;
    end
  end

  always @(posedge clk) if (rst_n && eng_start) starts <= starts + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!status[7]) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", rd_mode, 2'b00);
    chk("R1 status", status, 8'h80);
    chk("R1 ready", wr_ready, 1'b1);
    chk("R1 bcr", bcr, 16'h0000);
  endtask

  task automatic t_modes();
    wr(0, 32'hFF); chk("R2 array", rd_mode, 2'b00);
    wr(0, 32'h70); chk("R2 status mode", rd_mode, 2'b01);
    chk("R2 status data", rd_data, 32'h80);
    wr(0, 32'h90); chk("R2 sign mode", rd_mode, 2'b10);
    rd_idx = 1'b0; #1 chk("R2 mfr", rd_data, 32'h20);
    rd_idx = 1'b1; #1 chk("R2 dev", rd_data, {16'h0, DEV});
    rd_idx = 1'b0;
    wr(0, 32'h98); chk("R2 query", rd_mode, 2'b11);
    wr(0, 32'hFF);
  endtask

  task automatic t_erase();
    int s0;
    s0 = starts; lat = 6;
    wr(0, 32'h20); chk("R3 setup status", status, 8'h80);
    wr(19'h12000, 32'hD0);
    chk("R3 start", eng_start, 1'b1);
    chk("R3 op", eng_op, 1'b0);
    chk("R3 addr", eng_addr, 19'h12000);
    chk("R13 ready low", wr_ready, 1'b0);
    chk("R7 busy bit", status[7], 1'b0);
    wr(0, 32'hFF);
    chk("R7 forced status", rd_mode, 2'b01);
    wait_ready();
    chk("R7 deferred array", rd_mode, 2'b00);
    chk("R3 done status", status, 8'h80);
    chk("R3 one start", starts - s0, 1);
  endtask

  task automatic t_program_fail();
    fail_next = 1'b1; lat = 3;
    wr(0, 32'h40);
    wr(19'h00345, 32'hCAFEF00D);
    chk("R4 op", eng_op, 1'b1);
    chk("R4 addr", eng_addr, 19'h00345);
    chk("R4 data", eng_data, 32'hCAFEF00D);
    wait_ready();
    chk("R4 fail bit", status, 8'h90);
    fail_next = 1'b0;
    wr(0, 32'h50); chk("R11 clear", status, 8'h80);
  endtask

  task automatic t_seq_err();
    int s0;
    wr(0, 32'h20); wr(0, 32'hFF);
    chk("R8 bad confirm", status, 8'hB0);
    s0 = starts;
    wr(0, 32'h40); wr(19'h00100, 32'h12345678);
    wr(0, 32'h20); wr(19'h00100, 32'hD0);
    repeat (2) @(negedge clk);
    chk("R11 refused", starts - s0, 0);
    chk("R11 still sticky", status, 8'hB0);
    wr(0, 32'h50); chk("R11 cleared", status, 8'h80);
  endtask

  task automatic t_protect();
    int s0;
    s0 = starts;
    wr(0, 32'h40); prot_hit = 1'b1; wr(19'h00200, 32'h1);
    chk("R9 prog protected", status, 8'h82);
    prot_hit = 1'b0; wr(0, 32'h50);
    wr(0, 32'h20); prot_hit = 1'b1; wr(19'h00200, 32'hD0);
    chk("R9 erase protected", status, 8'h82);
    repeat (2) @(negedge clk);
    chk("R9 no start", starts - s0, 0);
    prot_hit = 1'b0; wr(0, 32'h50);
  endtask

  task automatic t_vpp();
    int s0;
    s0 = starts;
    vpp_ok = 1'b0;
    wr(0, 32'h20); wr(19'h00400, 32'hD0);
    chk("R10 low at confirm", status, 8'h88);
    chk("R10 no start", starts - s0, 0);
    vpp_ok = 1'b1; wr(0, 32'h50);
    lat = 20;
    wr(0, 32'h40); wr(19'h00400, 32'h55);
    repeat (4) @(negedge clk);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R10 abort pulse", eng_abort, 1'b1);
    chk("R10 abort status", status, 8'h88);
    vpp_ok = 1'b1;
    repeat (2) @(negedge clk);
    wr(0, 32'h50);
  endtask

  task automatic t_erase_susp();
    lat = 30;
    wr(0, 32'h20); wr(19'h40000, 32'hD0);
    repeat (3) @(negedge clk);
    wr(0, 32'hB0);
    chk("R5 suspend pulse", eng_suspend, 1'b1);
    wait_ready();
    chk("R5 erase held", status, 8'hC0);
    wr(0, 32'hFF); chk("R6 array in hold", rd_mode, 2'b00);
    lat = 4;
    wr(0, 32'h40); chk("R6 nested setup", status, 8'hC0);
    wr(19'h00010, 32'hA5A5A5A5);
    chk("R6 nested start", eng_start, 1'b1);
    chk("R6 nested op", eng_op, 1'b1);
    chk("R6 nested busy", status[7:6], 2'b01);
    wait_ready();
    chk("R6 back to held", status, 8'hC0);
    wr(0, 32'hD0);
    chk("R5 resume pulse", eng_resume, 1'b1);
    chk("R13 ready after resume", wr_ready, 1'b0);
    wait_ready();
    chk("R5 erase finished", status, 8'h80);
  endtask

  task automatic t_prog_susp();
    lat = 30;
    wr(0, 32'h40); wr(19'h00020, 32'h0F0F0F0F);
    repeat (3) @(negedge clk);
    wr(0, 32'hB0);
    wait_ready();
    chk("R5 program held", status, 8'h84);
    wr(0, 32'h20);
    chk("R5 erase ignored in program hold", status, 8'h84);
    wr(0, 32'hD0);
    wait_ready();
    chk("R5 program finished", status, 8'h80);
  endtask

  task automatic t_cfg();
    wr(0, 32'h60); wr(19'h0A5C3, 32'h03);
    chk("R12 load", bcr, 16'hA5C3);
    wr(0, 32'h60); wr(19'h01234, 32'h07);
    chk("R12 kept", bcr, 16'hA5C3);
    chk("R8 cfg error", status, 8'hB0);
    wr(0, 32'h50);
  endtask

  task automatic t_tune();
    tune_locked = 1'b1; #1
    chk("R1 tune bit", status[0], 1'b1);
    tune_locked = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_erase();
    t_program_fail();
    t_seq_err();
    t_protect();
    t_vpp();
    t_erase_susp();
    t_prog_susp();
    t_cfg();
    t_tune();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule